// File: doc/BRIEF.md
# Audio Serial Transmitter with Runtime Slot Depth

This block drives a three-wire stereo audio link as bus master. It generates the bit clock (SCK) and the channel-select line (WS), and it serialises audio data onto SD. Time advances only on cycles where the step-enable input is high. Two steps make one SCK period. In the first step SCK is low and a new SD bit is driven. In the second step SCK goes high, so a receiver can capture SD on the rising edge.

The slot length is set at run time through a configuration input that holds the depth minus two. A value of 14 gives 16-bit slots, 22 gives 24-bit slots and 30 gives 32-bit slots. The block treats the data as one continuous MSB-first bit stream built from 32-bit words, which arrive through a valid/ready input. A new word is taken only after every bit of the previous word has been sent. With 16-bit slots, one word therefore carries a left and a right sample.

WS switches during the last bit of each slot, one bit ahead of the next slot's MSB. If no word is offered when one is needed, the block keeps SCK and WS running, sends zeros and flags the underrun.

Top module: `i2s_master_tx`

## Requirements
- R1: While reset is asserted and directly after it, sck, ws, sd, underrun and word_ready are all 0.
- R2: Every SD bit takes two steps. In the first step (sck driven low), sd takes the new bit. In the next step, sck goes high. On a cycle with step_en low, sck, ws and sd do not change.
- R3: A slot lasts depth_cfg + 2 bits. The values 14, 22 and 30 give 16-, 24- and 32-bit slots.
- R4: ws is 0 during left-channel bits and 1 during right-channel bits. It already shows the next channel during the final bit of each slot. The first slot after reset is left.
- R5: Data leaves as one continuous MSB-first stream of 32-bit words, with no alignment to slot boundaries. word_ready is high only in a bit's first step, and only when all 32 bits of the previous word have been sent. The word is accepted when word_valid is also high, and its bit 31 becomes that bit.
- R6: If word_ready is high and word_valid is low, the bit sent is 0 and underrun is 1 for that bit. The fetch is retried on the next bit, and sck and ws keep their normal sequence.
- R7: depth_cfg is sampled only at the first bit of a slot. A change made during a slot takes effect at the next slot.
- R8: depth_cfg values other than 14, 22 and 30 are used as given. For example, 0 gives 2-bit slots and 6 gives 8-bit slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Step tick; two ticks per SCK period |
| depth_cfg | input | CFG_W | Slot depth minus two |
| word_data | input | WORD_W | Next data word, MSB sent first |
| word_valid | input | 1 | word_data is available |
| word_ready | output | 1 | Block takes a word in this cycle if valid |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Channel select, 0 = left, 1 = right |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Current SD bit is filler because no word was offered |

## Verification
The bench runs 16-, 24- and 32-bit slots, where words straddle slot boundaries. A design that realigned words to slots, or sent the LSB first, would put the wrong bit on SD. It changes depth_cfg in the middle of a slot and checks the slot's WS edge. A design that sampled the depth at every bit would move that edge early. It also runs the odd depths 0 and 6, and an underrun gap followed by recovery. A design that stalled SCK or reused stale data would show a WS sequence or data that no longer matches the expected stream. Idle cycles between steps expose any output that moves without a step.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_tx_slot_ctrl.sv
module i2s_tx_slot_ctrl
    import i2s_tx_pkg::*;
#(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [CFG_W-1:0] depth_cfg,
    output logic             bit_step,
    output logic             sck,
    output logic             ws
);
    localparam int CNT_W = CFG_W + 1;

    typedef struct packed {
        logic             phase;   // 0: next step drives a new bit
        logic             sck;
        logic             ws;
        chan_e            chan;    // channel of the bit on the wire
        logic [CNT_W-1:0] cnt;     // bits left in slot after current
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
                st_d.sck   = 1'b0;
                if (st_q.cnt == '0) begin
                    st_d.chan = (st_q.chan == CH_LEFT) ? CH_RIGHT : CH_LEFT;
                    st_d.cnt  = {1'b0, depth_cfg} + CNT_W'(1);
                end else begin
                    st_d.cnt  = st_q.cnt - CNT_W'(1);
                end
                // final bit of a slot announces the next channel
                st_d.ws = (st_d.cnt == '0) ? ~st_d.chan : st_d.chan;
            end else begin
                st_d.phase = 1'b0;
                st_d.sck   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= 1'b0;
            st_q.sck   <= 1'b0;
            st_q.ws    <= 1'b0;
            st_q.chan  <= CH_RIGHT;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_step = step_en & ~st_q.phase;
    assign sck      = st_q.sck;
    assign ws       = st_q.ws;
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_step,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              sd,
    output logic              underrun
);
    localparam int LEFT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [LEFT_W-1:0] left;   // bits still to send from shreg
        logic              sd;
        logic              und;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   empty;

    assign empty      = (st_q.left == '0);
    assign word_ready = bit_step & empty;

    always_comb begin
        st_d = st_q;
        if (bit_step) begin
            if (empty) begin
                if (word_valid) begin
                    st_d.sd    = word_data[WORD_W-1];
                    st_d.shreg = {word_data[WORD_W-2:0], 1'b0};
                    st_d.left  = LEFT_W'(WORD_W - 1);
                    st_d.und   = 1'b0;
                end else begin
                    st_d.sd    = 1'b0;
                    st_d.und   = 1'b1;
                end
            end else begin
                st_d.sd    = st_q.shreg[WORD_W-1];
                st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
                st_d.left  = st_q.left - LEFT_W'(1);
                st_d.und   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd       = st_q.sd;
    assign underrun = st_q.und;
endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx #(
    parameter int WORD_W = 32,
    parameter int CFG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [CFG_W-1:0]  depth_cfg,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ready,
    output logic              sck,
    output logic              ws,
    output logic              sd,
    output logic              underrun
);
    logic bit_step;

    i2s_tx_slot_ctrl #(.CFG_W(CFG_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .depth_cfg (depth_cfg),
        .bit_step  (bit_step),
        .sck       (sck),
        .ws        (ws)
    );

    i2s_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_step   (bit_step),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .sd         (sd),
        .underrun   (underrun)
    );
endmodule

// File: rtl/i2s_master_tx_sva.sv
module i2s_master_tx_sva (
    input logic clk,
    input logic rst_n,
    input logic step_en,
    input logic word_ready,
    input logic sck,
    input logic ws,
    input logic sd,
    input logic underrun
);
    // R2: outputs hold on cycles without a step
    p_hold_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(sck) && $stable(ws) && $stable(sd)));

    // R2: sd only moves while sck is low
    p_sd_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd) |-> !sck);

    // R2: a step with sck high drives it low
    p_sck_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sck) |=> !sck);

    // R4: ws only moves while sck is low
    p_ws_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> !sck);

    // R5: fetch requests only happen on steps
    p_ready_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> step_en);

    // R6: filler bits are zero
    p_underrun_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !sd);
endmodule

bind i2s_master_tx i2s_master_tx_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .word_ready (word_ready),
    .sck        (sck),
    .ws         (ws),
    .sd         (sd),
    .underrun   (underrun)
);

// File: tb/i2s_master_tx_tb_top.sv
module i2s_master_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [4:0]  depth_cfg = 5'd14;
    logic [31:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic        word_ready, sck, ws, sd, underrun;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    i2s_master_tx dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .depth_cfg(depth_cfg),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
    );

    // stimulus word queue and expected-bit scoreboard {sd, ws, und}
    logic [31:0] wq[$];
    logic [2:0]  exp_q[$];

    // bench model state
    logic [31:0] m_word = '0;
    int          m_left = 0;
    int          m_rem  = 0;
    bit          m_chan = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one step; low steps push the expected bit into the scoreboard
    task automatic step_once(input bit low);
        bit take;
        bit e_sd, e_ws, e_und;
        @(negedge clk);
        step_en    = 1'b1;
        word_valid = (wq.size() > 0);
        word_data  = (wq.size() > 0) ? wq[0] : '0;
        #1;
        take = word_ready && word_valid;
        if (low) begin
            chk(word_ready == (m_left == 0), "R5 word_ready", 32'(word_ready), 32'(m_left == 0));
            e_und = 1'b0;
            if (m_left == 0) begin
                if (wq.size() > 0) begin
                    m_word = wq[0];
                    m_left = 32;
                end else begin
                    e_und = 1'b1;
                end
            end
            if (e_und) e_sd = 1'b0;
            else begin
                e_sd = m_word[m_left-1];
                m_left--;
            end
            if (m_rem == 0) begin
                m_chan = ~m_chan;
                m_rem  = int'(depth_cfg) + 2;
            end
            m_rem--;
            e_ws = (m_rem == 0) ? ~m_chan : m_chan;
            exp_q.push_back({e_sd, e_ws, e_und});
        end else begin
            chk(!word_ready, "R5 ready high step", 32'(word_ready), 32'd0);
        end
        @(posedge clk);
        #1;
        step_en    = 1'b0;
        word_valid = 1'b0;
        if (take) void'(wq.pop_front());
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) begin
            step_once(1'b1);
            step_once(1'b0);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        wq.push_back(w);
    endtask

    // monitor: compare on each rising sck
    logic prev_sck = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sck && !prev_sck) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_req, " unexpected bit"}, 32'd1, 32'd0);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                chk(sd == e[2], {cur_req, " sd"}, 32'(sd), 32'(e[2]));
                chk(ws == e[1], {cur_req, " ws"}, 32'(ws), 32'(e[1]));
                chk(underrun == e[0], {cur_req, " underrun"}, 32'(underrun), 32'(e[0]));
            end
        end
        prev_sck <= sck;
    end

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic s_sck, s_sd, s_ws;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({sck, ws, sd, underrun, word_ready} == 5'b0, "R1 in reset",
            32'({sck, ws, sd, underrun, word_ready}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sck, ws, sd, underrun, word_ready} == 5'b0, "R1 after reset",
            32'({sck, ws, sd, underrun, word_ready}), 32'd0);

        // R3 R4 R5: 16-bit slots, words span two slots
        cur_req = "R3 R4 R5 16-bit";
        depth_cfg = 5'd14;
        push_word(32'hA5F0_3C96); push_word(32'h8001_7FFE);
        push_word(32'h1234_5678); push_word(32'hFEDC_BA98);
        run_bits(128);

        // R2: idle cycles between steps leave outputs frozen
        cur_req = "R2 gaps";
        push_word(32'hC3C3_0F0F);
        run_bits(3);
        step_once(1'b1);
        @(negedge clk);
        s_sck = sck; s_sd = sd; s_ws = ws;
        repeat (5) @(negedge clk);
        chk({sck, sd, ws} == {s_sck, s_sd, s_ws}, "R2 hold low", 32'({sck, sd, ws}), 32'({s_sck, s_sd, s_ws}));
        chk(sck == 1'b0, "R2 sck low after first step", 32'(sck), 32'd0);
        step_once(1'b0);
        @(negedge clk);
        chk(sck == 1'b1, "R2 sck high after second step", 32'(sck), 32'd1);
        s_sd = sd;
        repeat (4) @(negedge clk);
        chk(sd == s_sd && sck, "R2 hold high", 32'({sck, sd}), 32'({1'b1, s_sd}));
        run_bits(28);

        // R3: 32-bit slots
        cur_req = "R3 R4 32-bit";
        depth_cfg = 5'd30;
        push_word(32'h0F1E_2D3C); push_word(32'h4B5A_6978);
        push_word(32'hDEAD_BEEF); push_word(32'h0000_0001);
        run_bits(128);

        // R3: 24-bit slots
        cur_req = "R3 R5 24-bit";
        depth_cfg = 5'd22;
        push_word(32'h9E37_79B9); push_word(32'h7F4A_7C15); push_word(32'hF39C_C060);
        run_bits(96);

        // R6: underrun then recovery
        cur_req = "R6 underrun";
        run_bits(10);
        push_word(32'hB00B_1E55);
        run_bits(40);

        // R7: mid-slot depth change
        cur_req = "R7 mid-slot change";
        depth_cfg = 5'd14;
        push_word(32'h5555_AAAA); push_word(32'h3333_CCCC);
        run_bits(13);
        depth_cfg = 5'd6;
        run_bits(40);

        // R8: nonstandard depths
        cur_req = "R8 depth 0";
        depth_cfg = 5'd0;
        push_word(32'h6969_9696);
        run_bits(36);
        cur_req = "R8 depth 6";
        depth_cfg = 5'd6;
        push_word(32'h0123_4567);
        run_bits(24);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule